// File: doc/BRIEF.md
# Synchronous Rectifier Gate Sequencer

This block generates the gate commands for the two switches of a center-tapped synchronous rectifier in a resonant converter. It does not copy the inverter gate pattern. Each rectifier channel is tied to one inverter half-bridge gate. That gate opens a turn-on window for the channel. Inside the window a conduction comparator flag may switch the channel on, but only once per switching period. A blanking interval then keeps the gate on regardless of ringing. After that, a cycle-by-cycle trip comparator ends conduction through a programmable delay.

The window can be stretched by a programmable number of clock cycles past the inverter edge that would otherwise close it. With zero stretch the gate is removed at that inverter edge, which is ahead of the steep current slope. All timing values are counts of the system clock and may be changed while running. A final guard forces both gates low whenever both channels would be driven together.

Top module: `sr_gate_seq`

## Requirements
- R1: Channel 0 (gate_o[0]) is released only by inv_a_i and channel 1 (gate_o[1]) only by inv_b_i. A channel is armed by a rising edge of its release input. While the release input is low and no stretch remains, the turn-on flag of that channel has no effect and its gate stays low.
- R2: A channel turns on at most once per release window. After it has turned off, further turn-on flags are ignored until the next rising edge of its release input. That edge arms the channel again.
- R3: In an armed channel, a high on_flag_i bit sampled at a clock edge while the window is open sets that channel's gate high directly after the same edge.
- R4: After turn-on, the gate stays high for at least min_on_i+1 cycles while the window stays open. The turn-off flag is ignored during this time.
- R5: When the window closes, the gate is forced low at the next clock edge. With ext_i = 0 the window closes at the edge where the release input is sampled low. With ext_i = N, it stays open for N further cycles after that edge.
- R6: Once the minimum on-time is over, an off_flag_i bit sampled high at an edge keeps the gate high for off_dly_i+1 further edges. The gate then goes low directly after the (off_dly_i+1)-th edge.
- R7: gate_o[0] and gate_o[1] are never high together. If both channels request the gate, both outputs are low.
- R8: During reset, and from the edge where en_i is sampled low, both gates are low and both channels return to their idle state. Turning on again afterwards needs a fresh rising edge of the release input.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all timers count its cycles |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Block enable; low clears both channels |
| inv_a_i | input | 1 | Inverter gate that releases channel 0 |
| inv_b_i | input | 1 | Inverter gate that releases channel 1 |
| on_flag_i | input | 2 | Per-channel conduction (turn-on) comparator flag |
| off_flag_i | input | 2 | Per-channel turn-off trip comparator flag |
| min_on_i | input | W | Minimum on-time blanking, in cycles (plus one) |
| ext_i | input | W | Window stretch past the closing inverter edge, in cycles |
| off_dly_i | input | W | Delay from trip to gate removal, in cycles (plus one) |
| gate_o | output | 2 | Rectifier gate commands, bit 0 = channel 0 |

## Verification
Some properties are checked on every cycle: the two gates never overlap, a disabled block drives both gates low on the next cycle, an internal channel request rises only after its turn-on flag, and a gate that ends before the blanking interval is over must have lost its window or its enable. The bench scenarios cover the sequence-dependent behaviour. These are the single turn-on per period despite repeated flags, the exact fall cycle after a trip, the exact number of stretch cycles, the masking while both channels request the gate, and re-arming after the enable returns.

// File: rtl/sr_gate_pkg.sv
package sr_gate_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_ARMED  = 3'd1,
        ST_ON_MIN = 3'd2,
        ST_ON     = 3'd3,
        ST_TOFF   = 3'd4,
        ST_DONE   = 3'd5
    } sr_state_e;

endpackage

// File: rtl/sr_release_window.sv
module sr_release_window #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en_i,
    input  logic         rel_i,
    input  logic [W-1:0] ext_i,
    output logic         rise_o,
    output logic         open_o
);
    typedef struct packed {
        logic         prev;
        logic [W-1:0] ext_cnt;
    } win_t;

    win_t r_d, r_q;

    always_comb begin
        r_d      = r_q;
        r_d.prev = rel_i;
        if (rel_i) begin
            r_d.ext_cnt = ext_i;
        end else if (r_q.ext_cnt != '0) begin
            r_d.ext_cnt = r_q.ext_cnt - 1'b1;
        end
        if (!en_i) begin
            r_d.ext_cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign rise_o = rel_i && !r_q.prev;
    assign open_o = rel_i || (r_q.ext_cnt != '0);

endmodule

// File: rtl/sr_channel.sv
module sr_channel
    import sr_gate_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en_i,
    input  logic         rise_i,
    input  logic         open_i,
    input  logic         on_flag_i,
    input  logic         off_flag_i,
    input  logic [W-1:0] min_on_i,
    input  logic [W-1:0] off_dly_i,
    output logic         gate_o
);
    typedef struct packed {
        sr_state_e    st;
        logic [W-1:0] cnt;
    } ch_t;

    ch_t c_d, c_q;

    always_comb begin
        c_d = c_q;
        case (c_q.st)
            ST_IDLE, ST_DONE: begin
                if (rise_i) c_d.st = ST_ARMED;
            end
            ST_ARMED: begin
                if (!open_i) begin
                    c_d.st = ST_DONE;
                end else if (on_flag_i) begin
                    c_d.st  = ST_ON_MIN;
                    c_d.cnt = min_on_i;
                end
            end
            ST_ON_MIN: begin
                if (!open_i) begin
                    c_d.st = ST_DONE;
                end else if (c_q.cnt == '0) begin
                    c_d.st = ST_ON;
                end else begin
                    c_d.cnt = c_q.cnt - 1'b1;
                end
            end
            ST_ON: begin
                if (!open_i) begin
                    c_d.st = ST_DONE;
                end else if (off_flag_i) begin
                    c_d.st  = ST_TOFF;
                    c_d.cnt = off_dly_i;
                end
            end
            ST_TOFF: begin
                if (!open_i || c_q.cnt == '0) begin
                    c_d.st = ST_DONE;
                end else begin
                    c_d.cnt = c_q.cnt - 1'b1;
                end
            end
            default: begin
                c_d.st = ST_IDLE;
            end
        endcase
        if (!en_i) begin
            c_d.st  = ST_IDLE;
            c_d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q <= '{st: ST_IDLE, cnt: '0};
        end else begin
            c_q <= c_d;
        end
    end

    assign gate_o = (c_q.st == ST_ON_MIN) || (c_q.st == ST_ON) || (c_q.st == ST_TOFF);

endmodule

// File: rtl/sr_overlap_guard.sv
module sr_overlap_guard #(
    parameter int NCH = 2
) (
    input  logic [NCH-1:0] req_i,
    output logic [NCH-1:0] gate_o
);
    always_comb begin
        gate_o = req_i;
        if ($countones(req_i) > 1) begin
            gate_o = '0;
        end
    end

endmodule

// File: rtl/sr_gate_seq.sv
module sr_gate_seq #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en_i,
    input  logic         inv_a_i,
    input  logic         inv_b_i,
    input  logic [1:0]   on_flag_i,
    input  logic [1:0]   off_flag_i,
    input  logic [W-1:0] min_on_i,
    input  logic [W-1:0] ext_i,
    input  logic [W-1:0] off_dly_i,
    output logic [1:0]   gate_o
);
    localparam int NCH = 2;

    logic [NCH-1:0] rel;
    logic [NCH-1:0] rise;
    logic [NCH-1:0] win_open;
    logic [NCH-1:0] raw_gate;

    assign rel = {inv_b_i, inv_a_i};

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        sr_release_window #(.W(W)) u_win (
            .clk    (clk),
            .rst_n  (rst_n),
            .en_i   (en_i),
            .rel_i  (rel[i]),
            .ext_i  (ext_i),
            .rise_o (rise[i]),
            .open_o (win_open[i])
        );

        sr_channel #(.W(W)) u_chan (
            .clk        (clk),
            .rst_n      (rst_n),
            .en_i       (en_i),
            .rise_i     (rise[i]),
            .open_i     (win_open[i]),
            .on_flag_i  (on_flag_i[i]),
            .off_flag_i (off_flag_i[i]),
            .min_on_i   (min_on_i),
            .off_dly_i  (off_dly_i),
            .gate_o     (raw_gate[i])
        );
    end

    sr_overlap_guard #(.NCH(NCH)) u_guard (
        .req_i  (raw_gate),
        .gate_o (gate_o)
    );

endmodule

// File: rtl/sr_gate_seq_chk.sv
module sr_gate_seq_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         en_i,
    input logic [1:0]   rel_i,
    input logic [1:0]   on_flag_i,
    input logic [W-1:0] min_on_i,
    input logic [1:0]   raw_i,
    input logic [1:0]   gate_o
);
    AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
        !(gate_o[0] && gate_o[1])); // R7

    AST_DISABLED_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> (gate_o == 2'b00)); // R8

    for (genvar i = 0; i < 2; i++) begin : g_chk
        logic [W:0] age_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                age_q <= '0;
            end else if (!raw_i[i]) begin
                age_q <= '0;
            end else if (age_q != '1) begin
                age_q <= age_q + 1'b1;
            end
        end

        AST_RISE_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(raw_i[i]) |-> $past(on_flag_i[i])); // R3

        AST_MIN_ON_HELD: assert property (@(posedge clk) disable iff (!rst_n)
            ($fell(raw_i[i]) && (age_q <= {1'b0, min_on_i}))
                |-> ($past(!rel_i[i]) || $past(!en_i))); // R4
    end

endmodule

bind sr_gate_seq sr_gate_seq_chk #(.W(W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .en_i      (en_i),
    .rel_i     (rel),
    .on_flag_i (on_flag_i),
    .min_on_i  (min_on_i),
    .raw_i     (raw_gate),
    .gate_o    (gate_o)
);

// File: tb/sr_gate_seq_test.sv
`timescale 1ns/1ps
module sr_gate_seq_test;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         en_i = 1'b0;
    logic         inv_a_i = 1'b0;
    logic         inv_b_i = 1'b0;
    logic [1:0]   on_flag_i = 2'b00;
    logic [1:0]   off_flag_i = 2'b00;
    logic [W-1:0] min_on_i = 8'd3;
    logic [W-1:0] ext_i = 8'd0;
    logic [W-1:0] off_dly_i = 8'd2;
    logic [1:0]   gate_o;

    int total = 0;
    int bad = 0;
    logic [1:0] exp_q[$];
    string      tag_q[$];

    always #5 clk = ~clk;

    sr_gate_seq #(.W(W)) uut (
        .clk(clk), .rst_n(rst_n), .en_i(en_i),
        .inv_a_i(inv_a_i), .inv_b_i(inv_b_i),
        .on_flag_i(on_flag_i), .off_flag_i(off_flag_i),
        .min_on_i(min_on_i), .ext_i(ext_i), .off_dly_i(off_dly_i),
        .gate_o(gate_o)
    );

    // driver: apply inputs for one edge and queue the gate value expected after it
    task automatic step(input logic a, input logic b, input logic [1:0] on,
                        input logic [1:0] off, input logic [1:0] exp, input string tag);
        @(negedge clk);
        inv_a_i    = a;
        inv_b_i    = b;
        on_flag_i  = on;
        off_flag_i = off;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
    endtask

    // monitor: compare after each edge
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (exp_q.size() > 0) begin
                logic [1:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                total++;
                if (gate_o !== e) begin
                    bad++;
                    $display("FAIL %s: gate_o=%b expected=%b at %0t", t, gate_o, e, $time);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: run did not finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #2;
        total++;
        if (gate_o !== 2'b00) begin
            bad++;
            $display("FAIL R8 reset: gate_o=%b expected=00", gate_o);
        end
        @(negedge clk);
        rst_n = 1'b1;
        en_i  = 1'b1;

        // R1: channel 0 inhibited before release, channel 1 never released
        step(0, 0, 2'b11, 2'b00, 2'b00, "R1 inhibit");
        step(1, 0, 2'b10, 2'b00, 2'b00, "R1 arm ch0");
        step(1, 0, 2'b10, 2'b00, 2'b00, "R3 wait flag");
        step(1, 0, 2'b11, 2'b00, 2'b01, "R3 turn on");
        // R4: trip ignored during blanking (min_on=3 -> 4 cycles ON_MIN)
        step(1, 0, 2'b10, 2'b01, 2'b01, "R4 blank");
        step(1, 0, 2'b10, 2'b01, 2'b01, "R4 blank");
        step(1, 0, 2'b10, 2'b01, 2'b01, "R4 blank");
        step(1, 0, 2'b10, 2'b01, 2'b01, "R4 blank end");
        // R6: trip accepted, off_dly=2 -> falls after third edge
        step(1, 0, 2'b10, 2'b01, 2'b01, "R6 trip");
        step(1, 0, 2'b10, 2'b00, 2'b01, "R6 delay");
        step(1, 0, 2'b10, 2'b00, 2'b01, "R6 delay");
        step(1, 0, 2'b10, 2'b00, 2'b00, "R6 off");
        // R2: repeated flags in the same window ignored
        step(1, 0, 2'b01, 2'b00, 2'b00, "R2 single");
        step(1, 0, 2'b01, 2'b00, 2'b00, "R2 single");
        step(0, 0, 2'b01, 2'b00, 2'b00, "R2 single");

        // R5: channel 1, window closes with ext=0
        step(0, 1, 2'b00, 2'b00, 2'b00, "R1 arm ch1");
        step(0, 1, 2'b10, 2'b00, 2'b10, "R3 ch1 on");
        step(0, 0, 2'b10, 2'b00, 2'b00, "R5 forced off");

        // R5: stretch of 2 cycles; R2 re-arm of channel 0
        @(negedge clk);
        ext_i = 8'd2;
        step(1, 0, 2'b00, 2'b00, 2'b00, "R2 re-arm");
        step(1, 0, 2'b01, 2'b00, 2'b01, "R2 second period on");
        step(0, 0, 2'b00, 2'b00, 2'b01, "R5 stretch");
        step(0, 0, 2'b00, 2'b00, 2'b01, "R5 stretch");
        step(0, 0, 2'b00, 2'b00, 2'b00, "R5 stretch end");

        // R7: overlap while channel 0 is stretched
        @(negedge clk);
        ext_i = 8'd3;
        step(1, 0, 2'b00, 2'b00, 2'b00, "R7 arm");
        step(1, 0, 2'b01, 2'b00, 2'b01, "R7 ch0 on");
        step(0, 1, 2'b00, 2'b00, 2'b01, "R7 ch1 armed");
        step(0, 1, 2'b10, 2'b00, 2'b00, "R7 both masked");
        step(0, 1, 2'b00, 2'b00, 2'b00, "R7 both masked");
        step(0, 1, 2'b00, 2'b00, 2'b10, "R7 ch1 alone");

        // R8: disable clears channels; re-enable needs fresh edge
        @(negedge clk);
        ext_i = 8'd0;
        en_i  = 1'b0;
        step(0, 1, 2'b10, 2'b00, 2'b00, "R8 disable");
        @(negedge clk);
        en_i = 1'b1;
        step(0, 1, 2'b10, 2'b00, 2'b00, "R8 no edge");
        step(0, 1, 2'b10, 2'b00, 2'b00, "R8 no edge");
        step(0, 0, 2'b00, 2'b00, 2'b00, "R8 low");
        step(0, 1, 2'b00, 2'b00, 2'b00, "R8 re-arm");
        step(0, 1, 2'b10, 2'b00, 2'b10, "R8 on again");

        repeat (3) @(posedge clk);
        #3;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule